// File: doc/BRIEF.md
# Extended Multiply and Divide Unit

This block is a multicycle arithmetic engine for four wide operations on a 16-bit accumulator machine: signed 16-by-16 division, unsigned 32-by-16 division, signed 32-by-16 division, and signed 16-by-16 multiplication. The caller presents the three operand registers (D, X and Y) and an operation code with a one-cycle start pulse. When the work is finished the unit raises a one-cycle done pulse. With that pulse it gives the new register values, a write enable for each destination register, the N, Z, V and C flag values and a write enable for each flag.

The dividers work on magnitudes with a restoring shift-subtract loop that produces one quotient bit per clock. Signs are put back in a final cycle. The quotient truncates toward zero and the remainder takes the sign of the dividend. The multiply and every divide by zero skip the loop. Result and flag outputs stay unchanged between done pulses.

Top module: `xmd_unit`

## Requirements
- R1: With op = 0 (signed 16/16), D is the dividend and X the divisor, both two's complement. X receives the quotient truncated toward zero and D the remainder, which has the sign of the dividend. Only d_we and x_we are set.
- R2: After op = 0 the flags are Z = (quotient == 0), N = quotient bit 15, C = 0, and V = 1 exactly when the quotient lies outside -32768..32767. The only such case is -32768 / -1, which leaves X = 0x8000. All four flag enables are set.
- R3: With op = 1 (unsigned), the dividend is Y:D (Y high) and the divisor is X. Y receives quotient bits 15:0 and D the remainder, and only d_we and y_we are set. V = 1 when the quotient is 65536 or more, Z = (full quotient == 0), N = quotient bit 15 and C = 0.
- R4: With op = 2 (signed 32/16), Y:D and X are two's complement and the results go to the same registers as in R3. V = 1 when the quotient lies outside -32768..32767, N = quotient bit 15, Z = (full quotient == 0) and C = 0. Truncation and remainder sign follow R1.
- R5: With op = 3, the signed product D*Y is formed. D receives product bits 15:0 and Y bits 31:16. Z = (product == 0), N = product bit 31 and C = product bit 15. flag_we, ordered {N,Z,V,C} from bit 3 to bit 0, equals 4'b1101, so V is not written.
- R6: For any divide (op 0 to 2) with X = 0, C = 1 and flag_we = 4'b0001. No register enable is set, and the D, X, Y, N, Z and V outputs keep their previous values.
- R7: Count clock edges from the edge that samples start, which is edge 1. done is high after edge 18 for op 0, after edge 34 for op 1 and op 2, and after edge 2 for op 3 and for a divide by zero.
- R8: done lasts exactly one cycle. Register and flag enables are set only while done is high, and the result outputs hold their values after done.
- R9: A start pulse that arrives while an operation is in progress is ignored. The running operation finishes with its own result and timing.
- R10: After reset, done, all enables and all result and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op | input | 2 | 0 signed 16/16 div, 1 unsigned 32/16 div, 2 signed 32/16 div, 3 signed multiply |
| d_in | input | 16 | D operand |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| d_out | output | 16 | New D value |
| x_out | output | 16 | New X value |
| y_out | output | 16 | New Y value |
| d_we | output | 1 | Write D |
| x_we | output | 1 | Write X |
| y_we | output | 1 | Write Y |
| n_out | output | 1 | N flag value |
| z_out | output | 1 | Z flag value |
| v_out | output | 1 | V flag value |
| c_out | output | 1 | C flag value |
| flag_we | output | 4 | Flag write enables {N,Z,V,C} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the sign corners, where mixed-sign operands need a truncated quotient and a remainder that follows the dividend. A design that floors instead of truncating would be off by one on the quotient and would give the remainder the wrong sign. The two overflow divides, -32768/-1 and 0x80000000/-1, test whether the magnitude path is wide enough: a narrow path would wrap and clear V. Unsigned quotients of 65536 or more test V and the full-width Z, which a design looking only at the low 16 bits would get wrong. Divides by zero on every opcode and a start pulse issued mid-run test that nothing is written and that no second operation gets launched.

// File: rtl/xmd_unit.sv
module xmd_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [15:0] d_in,
  input  logic [15:0] x_in,
  input  logic [15:0] y_in,
  output logic [15:0] d_out,
  output logic [15:0] x_out,
  output logic [15:0] y_out,
  output logic        d_we,
  output logic        x_we,
  output logic        y_we,
  output logic        n_out,
  output logic        z_out,
  output logic        v_out,
  output logic        c_out,
  output logic [3:0]  flag_we,
  output logic        done
);
  localparam logic [1:0] OP_SDIV16 = 2'd0;
  localparam logic [1:0] OP_UDIV32 = 2'd1;
  localparam logic [1:0] OP_SDIV32 = 2'd2;
  localparam logic [1:0] OP_SMUL   = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t         st;
  logic [1:0]  op_q;
  logic [4:0]  cnt;
  logic [31:0] sh_q;
  logic [15:0] rem_q;
  logic [15:0] dvs_q;
  logic        qneg_q, rneg_q, dz_q;

  function automatic logic [15:0] mag16(input logic [15:0] v);
    return v[15] ? 16'(-v) : v;
  endfunction

  logic signed [31:0] prod;
  logic [31:0]        yd;
  assign prod = $signed(d_in) * $signed(y_in);
  assign yd   = {y_in, d_in};

  logic [16:0] trial;
  logic        fits;
  logic [15:0] diff;
  assign trial = {rem_q, sh_q[31]};
  assign fits  = trial >= {1'b0, dvs_q};
  assign diff  = trial[15:0] - dvs_q;

  logic [31:0]        qmag;
  logic signed [32:0] qs;
  logic [15:0]        rem_s;
  logic               sovf, uovf;
  assign qmag  = (op_q == OP_SDIV16) ? {16'b0, sh_q[15:0]} : sh_q;
  assign qs    = qneg_q ? -$signed({1'b0, qmag}) : $signed({1'b0, qmag});
  assign rem_s = rneg_q ? 16'(-rem_q) : rem_q;
  assign sovf  = (qs > 33'sd32767) || (qs < -33'sd32768);
  assign uovf  = |qmag[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; cnt <= '0; sh_q <= '0; rem_q <= '0;
      dvs_q <= '0; qneg_q <= 1'b0; rneg_q <= 1'b0; dz_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q  <= op;
          rem_q <= '0;
          dz_q  <= (op != OP_SMUL) && (x_in == 16'd0);
          case (op)
            OP_SDIV16: begin
              sh_q <= {mag16(d_in), 16'b0}; dvs_q <= mag16(x_in);
              qneg_q <= d_in[15] ^ x_in[15]; rneg_q <= d_in[15]; cnt <= 5'd15;
            end
            OP_UDIV32: begin
              sh_q <= yd; dvs_q <= x_in;
              qneg_q <= 1'b0; rneg_q <= 1'b0; cnt <= 5'd31;
            end
            OP_SDIV32: begin
              sh_q <= y_in[15] ? -yd : yd; dvs_q <= mag16(x_in);
              qneg_q <= y_in[15] ^ x_in[15]; rneg_q <= y_in[15]; cnt <= 5'd31;
            end
            default: begin
              sh_q <= prod; dvs_q <= '0;
              qneg_q <= 1'b0; rneg_q <= 1'b0; cnt <= '0;
            end
          endcase
          st <= ((op == OP_SMUL) || (x_in == 16'd0)) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          rem_q <= fits ? diff : trial[15:0];
          sh_q  <= {sh_q[30:0], fits};
          if (cnt == 5'd0) st <= S_FIN;
          else cnt <= cnt - 5'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out <= '0; x_out <= '0; y_out <= '0;
      d_we <= 1'b0; x_we <= 1'b0; y_we <= 1'b0;
      n_out <= 1'b0; z_out <= 1'b0; v_out <= 1'b0; c_out <= 1'b0;
      flag_we <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0; d_we <= 1'b0; x_we <= 1'b0; y_we <= 1'b0; flag_we <= '0;
      if (st == S_FIN) begin
        done <= 1'b1;
        if (dz_q) begin
          c_out <= 1'b1;
          flag_we <= 4'b0001;
        end else if (op_q == OP_SMUL) begin
          d_out <= sh_q[15:0]; y_out <= sh_q[31:16];
          d_we <= 1'b1; y_we <= 1'b1;
          n_out <= sh_q[31]; z_out <= (sh_q == 32'd0); c_out <= sh_q[15];
          flag_we <= 4'b1101;
        end else begin
          d_out <= rem_s; d_we <= 1'b1;
          if (op_q == OP_SDIV16) begin
            x_out <= qs[15:0]; x_we <= 1'b1;
          end else begin
            y_out <= qs[15:0]; y_we <= 1'b1;
          end
          n_out <= qs[15];
          z_out <= (qmag == 32'd0);
          v_out <= (op_q == OP_UDIV32) ? uovf : sovf;
          c_out <= 1'b0;
          flag_we <= 4'b1111;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we || x_we || y_we || (flag_we != 4'b0)) |-> done);

  // R5
  mul_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_SMUL) |-> !flag_we[1]);

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && dz_q) |=> (c_out && !d_we && !x_we && !y_we && $stable(d_out)
                               && $stable(x_out) && $stable(y_out)));

  // R1
  partial_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (rem_q < dvs_q));

  // R9
  run_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |=> (st != S_IDLE));
endmodule

// File: tb/xmd_unit_tb.sv
module xmd_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [15:0] d_in = '0, x_in = '0, y_in = '0;
  logic [15:0] d_out, x_out, y_out;
  logic d_we, x_we, y_we, n_out, z_out, v_out, c_out, done;
  logic [3:0] flag_we;

  int total = 0;
  int bad = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  xmd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .d_in(d_in), .x_in(x_in), .y_in(y_in),
    .d_out(d_out), .x_out(x_out), .y_out(y_out),
    .d_we(d_we), .x_we(x_we), .y_we(y_we),
    .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out),
    .flag_we(flag_we), .done(done)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [15:0] a_d, input logic [15:0] a_x,
                     input logic [15:0] a_y, input bit inj);
    logic [15:0] ed, ex, ey;
    logic en, ez, ev, ec;
    logic [3:0] ef;
    logic ewd, ewx, ewy;
    longint a, b, q, r;
    int lat, cyc;
    string tv, tf;
    ed = d_out; ex = x_out; ey = y_out;
    en = n_out; ez = z_out; ev = v_out; ec = c_out;
    ewd = 0; ewx = 0; ewy = 0;
    if (o != 2'd3 && a_x == 16'd0) begin
      ec = 1; ef = 4'b0001; lat = 2; tv = "R6"; tf = "R6";
    end else begin
      case (o)
        2'd0: begin
          a = $signed(a_d); b = $signed(a_x); q = a / b; r = a % b;
          ex = q[15:0]; ed = r[15:0]; ewx = 1; ewd = 1;
          en = q[15]; ez = (q == 0); ev = (q > 32767) || (q < -32768); ec = 0;
          ef = 4'hf; lat = 18; tv = "R1"; tf = "R2";
        end
        2'd1: begin
          a = {32'b0, a_y, a_d}; b = {48'b0, a_x}; q = a / b; r = a % b;
          ey = q[15:0]; ed = r[15:0]; ewy = 1; ewd = 1;
          en = q[15]; ez = (q == 0); ev = (q > 65535); ec = 0;
          ef = 4'hf; lat = 34; tv = "R3"; tf = "R3";
        end
        2'd2: begin
          a = $signed({a_y, a_d}); b = $signed(a_x); q = a / b; r = a % b;
          ey = q[15:0]; ed = r[15:0]; ewy = 1; ewd = 1;
          en = q[15]; ez = (q == 0); ev = (q > 32767) || (q < -32768); ec = 0;
          ef = 4'hf; lat = 34; tv = "R4"; tf = "R4";
        end
        default: begin
          a = $signed(a_d); b = $signed(a_y); q = a * b;
          ed = q[15:0]; ey = q[31:16]; ewd = 1; ewy = 1;
          en = q[31]; ez = (q[31:0] == 0); ec = q[15];
          ef = 4'b1101; lat = 2; tv = "R5"; tf = "R5";
        end
      endcase
    end
    if (inj) tv = "R9";
    @(negedge clk);
    op = o; d_in = a_d; x_in = a_x; y_in = a_y; start = 1'b1;
    cyc = 0;
    @(posedge clk); cyc++;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 100) begin
      if (inj && cyc == 5) begin
        op = 2'd3; d_in = ~a_d; y_in = ~a_y; x_in = 16'h0001; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == lat, inj ? "R9 latency" : "R7 latency", 64'(cyc), 64'(lat));
    chk({d_out, x_out, y_out} == {ed, ex, ey}, tv, {16'b0, d_out, x_out, y_out}, {16'b0, ed, ex, ey});
    chk({n_out, z_out, v_out, c_out, flag_we} == {en, ez, ev, ec, ef}, tf,
        64'({n_out, z_out, v_out, c_out, flag_we}), 64'({en, ez, ev, ec, ef}));
    chk({d_we, x_we, y_we} == {ewd, ewx, ewy}, tv, 64'({d_we, x_we, y_we}), 64'({ewd, ewx, ewy}));
    @(negedge clk);
    chk(!done && !d_we && !x_we && !y_we && flag_we == 4'b0 && {d_out, x_out, y_out} == {ed, ex, ey},
        "R8 hold", {15'b0, done, d_out, x_out, y_out}, {16'b0, ed, ex, ey});
  endtask

  initial begin
    logic [15:0] rd, rx, ry;
    logic [1:0] ro;
    int unsigned seedv;
    seedv = 32'd2024;
    void'($urandom(seedv));
    repeat (3) @(negedge clk);
    chk(!done && {d_out, x_out, y_out} == 48'b0 && {n_out, z_out, v_out, c_out} == 4'b0
        && {d_we, x_we, y_we} == 3'b0 && flag_we == 4'b0, "R10 reset",
        {15'b0, done, d_out, x_out, y_out}, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd0, 16'h8000, 16'hFFFF, 16'h0000, 0);
    run(2'd0, 16'd7, 16'hFFFE, 16'h0000, 0);
    run(2'h0, 16'hFFF9, 16'd2, 16'h0000, 0);
    run(2'd0, 16'd0, 16'd5, 16'h1234, 0);
    run(2'd0, 16'd3, 16'd7, 16'h0000, 0);
    run(2'd1, 16'h0000, 16'h0001, 16'h0001, 0);
    run(2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
    run(2'd1, 16'd5, 16'd9, 16'd0, 0);
    run(2'd2, 16'h0000, 16'hFFFF, 16'h8000, 0);
    run(2'd2, 16'h7960, 16'd7, 16'hFFFE, 0);
    run(2'd2, 16'd100, 16'hFFF9, 16'h0000, 0);
    run(2'd3, 16'h8000, 16'h0000, 16'h8000, 0);
    run(2'd3, 16'hFFFF, 16'h0000, 16'h0001, 0);
    run(2'd3, 16'h0000, 16'h0000, 16'h1234, 0);
    run(2'd3, 16'h00FF, 16'h0000, 16'h0081, 0);
    run(2'd0, 16'h1234, 16'h0000, 16'h5678, 0);
    run(2'd1, 16'h1234, 16'h0000, 16'h5678, 0);
    run(2'd2, 16'h1234, 16'h0000, 16'h5678, 0);
    run(2'd0, 16'hF000, 16'd3, 16'h0000, 1);
    for (int i = 0; i < 150; i++) begin
      ro = 2'($urandom_range(0, 3));
      rd = 16'($urandom);
      rx = ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom);
      ry = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom);
      if ($urandom_range(0, 3) == 0) rx = 16'($urandom_range(1, 5));
      run(ro, rd, rx, ry, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule